// File: doc/BRIEF.md
# Packed-Index Vector Table Lookup

This unit turns a dense field of narrow indices into a full 512-bit vector. It splits the field into fixed-width indices and uses each one to select an element of a 512-bit table operand. The selected elements are written side by side into the result. Elements are copied bit for bit, so the data type does not matter. A 4-bit mode picks the element size (8, 16, 32 or 64 bits) and the index width (2, 4 or 5 bits). The lane count is always the vector width divided by the element size.

Upstream logic has already chosen the table register and fetched the bytes that hold the indices. It presents the low 40 bytes of that source, together with the table and the mode, under a valid strobe. One clock later the unit returns the expanded vector with a valid flag. A common use is to follow an interval search with this lookup, which fetches per-interval coefficients for piecewise function approximation.

Top module: `lut_expand`

## Requirements
- R1: While `rst_n` is low, `out_valid` is 0 and `out_result` is all zeros.
- R2: `out_valid` is high exactly in the cycle after a cycle with `in_valid` high, so the latency is one clock.
- R3: The mode selects the element size and index width as follows:
  - mode 7: 32-bit elements, 2-bit indices
  - mode 8: 16-bit elements, 2-bit indices
  - mode 9: 8-bit elements, 2-bit indices
  - mode 10: 64-bit elements, 4-bit indices
  - mode 11: 32-bit elements, 4-bit indices
  - mode 12: 16-bit elements, 4-bit indices
  - mode 13: 8-bit elements, 4-bit indices
  - mode 14: 16-bit elements, 5-bit indices
  - mode 15: 8-bit elements, 5-bit indices
  - The lane count is 512 divided by the element size.
- R4: The index for output lane i is the unsigned value in bits [i*W +: W] of `in_index_field`, where W is the index width.
- R5: Output lane i, which is bits [i*E +: E] of `out_result` for element size E, is a raw copy of table bits [k*E +: E], where k is the index for that lane. Lane 0 is the least significant element.
- R6: The table byte offset is (index × element bytes) modulo 64. In mode 10 this means index bit 3 has no effect, and indices 8–15 select the same entries as 0–7.
- R7: Bits of `in_index_field` at or above lanes × W do not affect the result.
- R8: A mode outside 7–15 that is presented with `in_valid` produces an all-zero result, and `out_valid` still follows R2.
- R9: In a cycle after one with `in_valid` low, `out_result` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request strobe |
| in_mode | input | 4 | Lookup mode, 7 to 15 |
| in_index_field | input | 320 | Densely packed indices, lane 0 in the low bits |
| in_table | input | 512 | Table vector, element 0 in the low bits |
| out_valid | output | 1 | Result strobe, one cycle after the request |
| out_result | output | 512 | Expanded vector |

## Verification
Some behaviours are checked by the assertions on every cycle:
- the reset state;
- the one-cycle valid relation;
- the result holding its value when idle;
- the zero result for unsupported modes;
- lane 0 in the 8-bit/2-bit mode;
- lane 0 in the 64-bit mode, including the dropped top index bit.

The full per-lane mapping for every mode can only be shown by the bench's scenarios. The same applies to the placement of the packed index fields and the insensitivity to unused high field bits. These scenarios compare whole 512-bit results against a byte-offset model, using random tables and indices and a few directed patterns.

// File: rtl/lut_pkg.sv
package lut_pkg;

   localparam int LUT_VEC_BITS   = 512;
   localparam int LUT_FIELD_BITS = 320;
   localparam int LUT_MODE_W     = 4;
   localparam int LUT_MODE_FIRST = 7;
   localparam int LUT_MODE_LAST  = 15;

   // element size in bytes for a lookup mode (0 for unsupported)
   function automatic int elem_bytes_of(input int mode);
      case (mode)
         7, 11:      return 4;
         8, 12, 14:  return 2;
         9, 13, 15:  return 1;
         10:         return 8;
         default:    return 0;
      endcase
   endfunction

   // packed index width in bits for a lookup mode (0 for unsupported)
   function automatic int idx_bits_of(input int mode);
      case (mode)
         7, 8, 9:          return 2;
         10, 11, 12, 13:   return 4;
         14, 15:           return 5;
         default:          return 0;
      endcase
   endfunction

   // bits of the packed field a mode consumes
   function automatic int field_use_of(input int mode, input int vec_bytes);
      if (elem_bytes_of(mode) == 0) return 0;
      return (vec_bytes / elem_bytes_of(mode)) * idx_bits_of(mode);
   endfunction

endpackage

// File: rtl/lut_mode_decode.sv
module lut_mode_decode #(
   parameter int MODE_W     = 4,
   parameter int MODE_FIRST = 7,
   parameter int MODE_LAST  = 15,
   localparam int NVAR      = MODE_LAST - MODE_FIRST + 1,
   localparam int VAR_W     = (NVAR > 1) ? $clog2(NVAR) : 1
) (
   input  logic [MODE_W-1:0] mode,
   output logic              legal,
   output logic [VAR_W-1:0]  var_sel
);

   if (MODE_FIRST > MODE_LAST) begin : g_bad_range
      $error("lut_mode_decode: empty mode range");
   end
   if (MODE_LAST >= (1 << MODE_W)) begin : g_bad_width
      $error("lut_mode_decode: mode range exceeds mode width");
   end

   logic [MODE_W:0] rel;

   always_comb begin
      rel   = {1'b0, mode} - (MODE_W+1)'(MODE_FIRST);
      legal = (mode >= MODE_W'(MODE_FIRST)) && (mode <= MODE_W'(MODE_LAST));
      var_sel = legal ? VAR_W'(rel) : '0;
   end

endmodule

// File: rtl/lut_gather.sv
module lut_gather #(
   parameter int VEC_BITS   = 512,
   parameter int ELEM_BYTES = 4,
   parameter int IDX_BITS   = 2,
   localparam int VEC_BYTES = VEC_BITS / 8,
   localparam int EW        = ELEM_BYTES * 8,
   localparam int LANES     = VEC_BYTES / ELEM_BYTES,
   localparam int SEL_W     = (LANES > 1) ? $clog2(LANES) : 1,
   localparam int OFF_W     = $clog2(VEC_BYTES),
   localparam int EB_SHIFT  = $clog2(ELEM_BYTES),
   localparam int USE_BITS  = LANES * IDX_BITS
) (
   input  logic [USE_BITS-1:0] idx_field,
   input  logic [VEC_BITS-1:0] table_vec,
   output logic [VEC_BITS-1:0] result
);

   if ((ELEM_BYTES & (ELEM_BYTES - 1)) != 0) begin : g_bad_elem
      $error("lut_gather: element bytes must be a power of two");
   end
   if (VEC_BYTES % ELEM_BYTES != 0) begin : g_bad_div
      $error("lut_gather: element size must divide the vector");
   end
   if (IDX_BITS < 1 || IDX_BITS > 8) begin : g_bad_idx
      $error("lut_gather: index width out of range");
   end

   logic [EW-1:0] elems [LANES];

   for (genvar e = 0; e < LANES; e++) begin : g_elem
      assign elems[e] = table_vec[e*EW +: EW];
   end

   for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
      logic [IDX_BITS-1:0] idx;
      logic [OFF_W-1:0]    boff;
      logic [SEL_W-1:0]    sel;

      assign idx  = idx_field[ln*IDX_BITS +: IDX_BITS];
      // byte offset wraps inside the vector; surplus index bits fall away
      assign boff = OFF_W'(32'(idx) * ELEM_BYTES);
      assign sel  = SEL_W'(boff >> EB_SHIFT);
      assign result[ln*EW +: EW] = elems[sel];
   end

endmodule

// File: rtl/lut_result_reg.sv
module lut_result_reg #(
   parameter int VEC_BITS = 512
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                capture,
   input  logic                legal,
   input  logic [VEC_BITS-1:0] candidate,
   output logic                valid_q,
   output logic [VEC_BITS-1:0] data_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_q <= 1'b0;
         data_q  <= '0;
      end else begin
         valid_q <= capture;
         if (capture) begin
            data_q <= legal ? candidate : '0;
         end
      end
   end

endmodule

// File: rtl/lut_expand.sv
module lut_expand
   import lut_pkg::*;
#(
   parameter int VEC_BITS   = LUT_VEC_BITS,
   parameter int FIELD_BITS = LUT_FIELD_BITS,
   parameter int MODE_W     = LUT_MODE_W,
   parameter int MODE_FIRST = LUT_MODE_FIRST,
   parameter int MODE_LAST  = LUT_MODE_LAST
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  in_valid,
   input  logic [MODE_W-1:0]     in_mode,
   input  logic [FIELD_BITS-1:0] in_index_field,
   input  logic [VEC_BITS-1:0]   in_table,
   output logic                  out_valid,
   output logic [VEC_BITS-1:0]   out_result
);

   localparam int VEC_BYTES = VEC_BITS / 8;
   localparam int NVAR      = MODE_LAST - MODE_FIRST + 1;
   localparam int VAR_W     = (NVAR > 1) ? $clog2(NVAR) : 1;

   if (VEC_BITS % 64 != 0) begin : g_bad_vec
      $error("lut_expand: vector width must be a multiple of 64");
   end
   for (genvar m = MODE_FIRST; m <= MODE_LAST; m++) begin : g_field_chk
      if (field_use_of(m, VEC_BYTES) > FIELD_BITS) begin : g_short
         $error("lut_expand: index field too narrow for a mode");
      end
      if (elem_bytes_of(m) == 0) begin : g_nomode
         $error("lut_expand: mode range contains an unsupported mode");
      end
   end

   logic             legal;
   logic [VAR_W-1:0] var_sel;

   lut_mode_decode #(
      .MODE_W     (MODE_W),
      .MODE_FIRST (MODE_FIRST),
      .MODE_LAST  (MODE_LAST)
   ) u_decode (
      .mode    (in_mode),
      .legal   (legal),
      .var_sel (var_sel)
   );

   logic [VEC_BITS-1:0] cand [NVAR];

   for (genvar m = MODE_FIRST; m <= MODE_LAST; m++) begin : g_variant
      localparam int EB  = elem_bytes_of(m);
      localparam int IB  = idx_bits_of(m);
      localparam int USE = field_use_of(m, VEC_BYTES);

      lut_gather #(
         .VEC_BITS   (VEC_BITS),
         .ELEM_BYTES (EB),
         .IDX_BITS   (IB)
      ) u_gather (
         .idx_field (in_index_field[USE-1:0]),
         .table_vec (in_table),
         .result    (cand[m-MODE_FIRST])
      );
   end

   logic [VEC_BITS-1:0] picked;

   always_comb begin
      picked = '0;
      for (int v = 0; v < NVAR; v++) begin
         if (var_sel == VAR_W'(v)) picked = cand[v];
      end
   end

   lut_result_reg #(
      .VEC_BITS (VEC_BITS)
   ) u_out (
      .clk       (clk),
      .rst_n     (rst_n),
      .capture   (in_valid),
      .legal     (legal),
      .candidate (picked),
      .valid_q   (out_valid),
      .data_q    (out_result)
   );

endmodule

// File: rtl/lut_expand_chk.sv
module lut_expand_chk #(
   parameter int VEC_BITS = 512,
   parameter int MODE_W   = 4
) (
   input logic                clk,
   input logic                rst_n,
   input logic                in_valid,
   input logic [MODE_W-1:0]   in_mode,
   input logic [3:0]          idx_lo,
   input logic [VEC_BITS-1:0] in_table,
   input logic                out_valid,
   input logic [VEC_BITS-1:0] out_result
);

   logic [63:0] m10_lane0;
   logic [7:0]  m9_lane0;

   assign m10_lane0 = 64'(in_table >> {idx_lo[2:0], 6'd0});
   assign m9_lane0  = 8'(in_table >> {idx_lo[1:0], 3'd0});

   a_r1_reset_clears: assert property (@(posedge clk)
      !rst_n |=> (!out_valid && out_result == '0));

   a_r2_valid_rise: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);

   a_r2_valid_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);

   a_r9_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> $stable(out_result));

   a_r8_bad_mode_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_mode < MODE_W'(7)) |=> out_result == '0);

   a_r5_byte_lane0: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_mode == MODE_W'(9)) |=> out_result[7:0] == $past(m9_lane0));

   a_r6_wide_lane0: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_mode == MODE_W'(10)) |=> out_result[63:0] == $past(m10_lane0));

endmodule

bind lut_expand lut_expand_chk #(
   .VEC_BITS (VEC_BITS),
   .MODE_W   (MODE_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .in_valid   (in_valid),
   .in_mode    (in_mode),
   .idx_lo     (in_index_field[3:0]),
   .in_table   (in_table),
   .out_valid  (out_valid),
   .out_result (out_result)
);

// File: tb/lut_expand_test.sv
`timescale 1ns/1ps
module lut_expand_test;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         in_valid = 1'b0;
   logic [3:0]   in_mode = 4'd7;
   logic [319:0] in_index_field = '0;
   logic [511:0] in_table = '0;
   logic         out_valid;
   logic [511:0] out_result;

   int n_checks = 0;
   int n_fails  = 0;

   always #2.5 clk = ~clk;

   lut_expand uut (
      .clk            (clk),
      .rst_n          (rst_n),
      .in_valid       (in_valid),
      .in_mode        (in_mode),
      .in_index_field (in_index_field),
      .in_table       (in_table),
      .out_valid      (out_valid),
      .out_result     (out_result)
   );

   function automatic int eb_of(input int m);
      if (m == 10) return 8;
      if (m == 7 || m == 11) return 4;
      if (m == 8 || m == 12 || m == 14) return 2;
      return 1;
   endfunction

   function automatic int ib_of(input int m);
      if (m <= 9) return 2;
      if (m <= 13) return 4;
      return 5;
   endfunction

   // byte-offset model taken from R3..R8
   function automatic logic [511:0] model(input int m, input logic [319:0] f,
                                          input logic [511:0] t);
      logic [511:0] r = '0;
      if (m < 7 || m > 15) return r;
      for (int ln = 0; ln < 64 / eb_of(m); ln++) begin
         int idx = 0;
         int off;
         for (int b = 0; b < ib_of(m); b++)
            idx |= int'(f[ln*ib_of(m) + b]) << b;
         off = (idx * eb_of(m)) % 64;
         for (int b = 0; b < eb_of(m); b++)
            r[(ln*eb_of(m) + b)*8 +: 8] = t[(off + b)*8 +: 8];
      end
      return r;
   endfunction

   function automatic logic [511:0] rnd512();
      logic [511:0] v;
      for (int i = 0; i < 16; i++) v[i*32 +: 32] = $urandom();
      return v;
   endfunction

   task automatic check(input string req, input logic [511:0] act,
                        input logic [511:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // drive one request, sample the registered result one edge later
   task automatic run(input int m, input logic [319:0] f, input logic [511:0] t,
                      input logic [511:0] exp, input string req);
      @(negedge clk);
      in_valid = 1'b1;
      in_mode = 4'(m);
      in_index_field = f;
      in_table = t;
      @(negedge clk);
      in_valid = 1'b0;
      check("R2 valid", 512'(out_valid), 512'(1));
      check(req, out_result, exp);
   endtask

   initial begin
      #(200000 * 5);
      n_checks++;
      n_fails++;
      $display("FAIL R2 watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   end

   initial begin
      logic [511:0] t;
      logic [319:0] f;
      logic [511:0] e;
      logic [511:0] held;
      void'($urandom(32'd4242));

      // R1 reset state
      repeat (3) @(negedge clk);
      check("R1 valid", 512'(out_valid), 512'(0));
      check("R1 result", out_result, '0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R2 idle", 512'(out_valid), 512'(0));

      // R4 directed: mode 13, byte k of table is k, lane i index i%16
      for (int k = 0; k < 64; k++) t[k*8 +: 8] = 8'(k);
      f = '0;
      for (int i = 0; i < 64; i++) f[i*4 +: 4] = 4'(i % 16);
      for (int i = 0; i < 64; i++) e[i*8 +: 8] = 8'(i % 16);
      run(13, f, t, e, "R4 lane placement");

      // R6 directed: mode 10, indices 8..15 act as 0..7
      t = rnd512();
      f = rnd512()[319:0];
      for (int i = 0; i < 8; i++) f[i*4 +: 4] = 4'(8 + ((i * 3) % 8));
      for (int i = 0; i < 8; i++) e[i*64 +: 64] = t[((i * 3) % 8)*64 +: 64];
      run(10, f, t, e, "R6 top index bit dropped");

      // R7: mode 7 uses 32 field bits; garbage above must not matter
      t = rnd512();
      f = rnd512()[319:0];
      e = model(7, {288'd0, f[31:0]}, t);
      run(7, f, t, e, "R7 unused field bits");

      // R8: unsupported modes give zero
      run(3, rnd512()[319:0], rnd512(), '0, "R8 mode 3");
      run(0, rnd512()[319:0], rnd512(), '0, "R8 mode 0");

      // R9: idle cycles hold the result while inputs change
      held = out_result;
      t = rnd512();
      f = rnd512()[319:0];
      run(15, f, t, model(15, f, t), "R5 mode 15");
      held = out_result;
      @(negedge clk);
      in_mode = 4'd9;
      in_table = rnd512();
      in_index_field = rnd512()[319:0];
      @(negedge clk);
      check("R9 valid low", 512'(out_valid), 512'(0));
      check("R9 hold", out_result, held);

      // R3/R5 random sweep over all modes
      for (int m = 7; m <= 15; m++) begin
         for (int n = 0; n < 25; n++) begin
            t = rnd512();
            f = rnd512()[319:0];
            run(m, f, t, model(m, f, t), "R3 R5 random mode");
         end
      end

      // back-to-back requests keep valid high every cycle (R2)
      @(negedge clk);
      for (int n = 0; n < 10; n++) begin
         int m = 7 + int'($urandom_range(8));
         in_valid = 1'b1;
         in_mode = 4'(m);
         t = rnd512();
         f = rnd512()[319:0];
         in_table = t;
         in_index_field = f;
         @(negedge clk);
         check("R2 streaming valid", 512'(out_valid), 512'(1));
         check("R5 streaming", out_result, model(m, f, t));
      end
      in_valid = 1'b0;
      @(negedge clk);

      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   end

endmodule